// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Write Engine

This block sets hidden tuning bits inside an analog transceiver PHY. It has one 32-bit control register, `ctl_reg`, and builds each tuning transfer as a fixed series of register updates. Every bit of a transfer is a separate transaction with four parts. First, the PHY-internal address goes into an 8-bit field. Next, the current data bit goes into a single flag bit. The strobe line of the selected PHY is pulled low at the same time. Last, that strobe is raised and then dropped so the PHY latches the bit. The address goes up by one for each bit, and the data word is sent least significant bit first.

A transfer can come from three places:
- a direct request that carries an address, a data word, a bit count and a PHY number;
- a squelch-detect request that turns the squelch detector on or off;
- a power-up sequencer that issues, in a fixed order, the resistor-calibration write (only for PHY 0), the transmit magnitude/rate write and the disconnect-threshold write.

In a mode for newer register layouts, the whole register is first written to zero once, before each transfer's bit loop starts.

Top module: `phy_tune_writer`

## Requirements
- R1: For bit i of a transfer, the register's bits 15:8 are rewritten to (start address + i) mod 256, and the other bits are left as they were.
- R2: Bit 7 carries the data, least significant bit first. The step that writes bit i places data[i] there.
- R3: PHY n (0..3) has its strobe on register bit 2n. That strobe is low in the data step, high in the next step and low again in the step after that. No two strobe bits are ever high together.
- R4: When `cfg_clear_first` is 1 at acceptance, the first write of the transfer is all zeros. It comes before the first address step.
- R5: Each register step takes one clock and gives one `ctl_wr` pulse. A transfer makes 4 writes per bit, plus the clearing write when R4 applies. `done` pulses once, together with the final strobe-low write.
- R6: `busy` goes high in the cycle after a request is accepted and stays high until the final strobe falls. Any request presented while `busy` is high is dropped and causes no register write.
- R7: A length of 0 makes no register write and leaves `busy` low. `done` pulses in the cycle after acceptance.
- R8: A length above 8 is treated as 8.
- R9: The power-up sequence for PHY 0 writes value 1, length 1, at address 0x0c. It then writes value 0x14, length 5, at address 0x20. Last, it writes `cfg_disc_thresh`, length 2, at address 0x2a. For any other PHY the first of these writes is skipped. `busy` stays high over the whole sequence.
- R10: A squelch request writes length 2 at address 0x3c. The value is 0 when `sq_on` is 1 and 2 when `sq_on` is 0.
- R11: If several requests arrive together while idle, the power-up request wins, then the squelch request, then the direct request. The requests that lose are dropped.
- R12: After reset, `ctl_reg` is zero and `busy`, `done` and `ctl_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clear_first | input | 1 | Zero the register once before each transfer |
| cfg_disc_thresh | input | 2 | Disconnect-threshold value used by the power-up sequence |
| phy_sel | input | 2 | Target PHY for the request being presented |
| wr_req | input | 1 | Direct transfer request |
| wr_addr | input | 8 | Start address of the direct transfer |
| wr_data | input | 8 | Data word of the direct transfer |
| wr_len | input | 4 | Bit count of the direct transfer |
| init_req | input | 1 | Start the power-up tuning sequence |
| sq_req | input | 1 | Squelch-detect control request |
| sq_on | input | 1 | 1 enables squelch detect, 0 disables it |
| busy | output | 1 | A transfer or sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of each transfer |
| ctl_wr | output | 1 | Register write strobe, one per step |
| ctl_reg | output | 32 | Control register value |

## Verification
Two kinds of request can come in the same idle cycle. In one case the power-up, squelch and direct requests are all presented together. In another, only squelch and direct come together. A scoreboard then expects only the writes of the winning request, so any write from a losing request shows up as an unexpected entry. Requests also arrive while a transfer is still running. Each of these cases is judged at the register port. The bench compares every `ctl_wr` write in order with a model register, and it compares the number of `done` pulses with the number of transfers the model predicts.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  localparam int CTL_W  = 32;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 4;
  localparam int PHY_W  = 2;
  localparam int NUM_PHY = 4;
  localparam int AFLD_LSB = 8;
  localparam int DBIT     = 7;

  localparam logic [ADDR_W-1:0] ADR_CAL  = 8'h0c;
  localparam logic [ADDR_W-1:0] ADR_AMP  = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_DISC = 8'h2a;
  localparam logic [ADDR_W-1:0] ADR_SQ   = 8'h3c;
  localparam logic [DATA_W-1:0] VAL_CAL    = 8'h01;
  localparam logic [DATA_W-1:0] VAL_AMP    = 8'h14;
  localparam logic [DATA_W-1:0] VAL_SQ_ON  = 8'h00;
  localparam logic [DATA_W-1:0] VAL_SQ_OFF = 8'h02;
  localparam logic [LEN_W-1:0]  LEN_CAL  = 4'd1;
  localparam logic [LEN_W-1:0]  LEN_AMP  = 4'd5;
  localparam logic [LEN_W-1:0]  LEN_DISC = 4'd2;
  localparam logic [LEN_W-1:0]  LEN_SQ   = 4'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [LEN_W-1:0]  len;
    logic [PHY_W-1:0]  phy;
  } tune_req_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR, ST_ADDR, ST_DATA, ST_STRH, ST_STRL
  } eng_state_e;
endpackage

// File: rtl/tune_bit_engine.sv
module tune_bit_engine
  import phy_tune_pkg::*;
#(
  parameter int P_CTL_W  = CTL_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_LEN_W  = LEN_W,
  parameter int P_NUM_PHY = NUM_PHY
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  tune_req_t          req,
  input  logic               clear_first,
  output logic               eng_busy,
  output logic               done,
  output logic               ctl_wr,
  output logic [P_CTL_W-1:0] ctl_reg
);
  localparam int STB_W = $clog2(P_CTL_W);
  localparam logic [P_LEN_W-1:0] MAX_LEN = P_LEN_W'(P_DATA_W);

  eng_state_e              state;
  logic [P_CTL_W-1:0]      ctl_q;
  logic                    wr_q, done_q;
  logic [P_ADDR_W-1:0]     base_q, idx_q;
  logic [P_DATA_W-1:0]     data_q;
  logic [P_LEN_W-1:0]      left_q;
  logic [STB_W-1:0]        stb_q;
  logic [P_LEN_W-1:0]      len_clamp;
  logic [P_CTL_W-1:0]      stb_all;

  // mask of every strobe position any PHY may use
  for (genvar g = 0; g < P_CTL_W; g++) begin : g_stb
    assign stb_all[g] = ((g % 2) == 0) && ((g / 2) < P_NUM_PHY);
  end

  assign len_clamp = (req.len > MAX_LEN) ? MAX_LEN : req.len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ctl_q  <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
      left_q <= '0;
      stb_q  <= '0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (len_clamp == '0) begin
              done_q <= 1'b1;
            end else begin
              base_q <= req.addr;
              idx_q  <= '0;
              data_q <= req.data;
              left_q <= len_clamp;
              stb_q  <= STB_W'({req.phy, 1'b0});
              state  <= clear_first ? ST_CLR : ST_ADDR;
            end
          end
        end
        ST_CLR: begin
          ctl_q <= '0;
          wr_q  <= 1'b1;
          state <= ST_ADDR;
        end
        ST_ADDR: begin
          ctl_q[AFLD_LSB +: P_ADDR_W] <= base_q + idx_q;
          wr_q  <= 1'b1;
          state <= ST_DATA;
        end
        ST_DATA: begin
          ctl_q[DBIT]  <= data_q[0];
          ctl_q[stb_q] <= 1'b0;
          wr_q  <= 1'b1;
          state <= ST_STRH;
        end
        ST_STRH: begin
          ctl_q[stb_q] <= 1'b1;
          wr_q  <= 1'b1;
          state <= ST_STRL;
        end
        ST_STRL: begin
          ctl_q[stb_q] <= 1'b0;
          wr_q   <= 1'b1;
          data_q <= data_q >> 1;
          idx_q  <= idx_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == P_LEN_W'(1)) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_ADDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign eng_busy = (state != ST_IDLE);
  assign done     = done_q;
  assign ctl_wr   = wr_q;
  assign ctl_reg  = ctl_q;

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(ctl_q & stb_all) <= 1);
  assert_strobe_falls_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRL) |=> (ctl_q[stb_q] == 1'b0 && wr_q));
  assert_strobe_high_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRH) |=> (ctl_q[stb_q] == 1'b1));
  assert_addr_field_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (ctl_q[AFLD_LSB +: P_ADDR_W] == base_q + idx_q));
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR) |=> (ctl_q == '0));
  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> (state == ST_IDLE));
  assert_len_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (start && len_clamp == '0) |=> (done_q && !wr_q && state == ST_IDLE));
endmodule

// File: rtl/tune_init_seq.sv
module tune_init_seq
  import phy_tune_pkg::*;
#(
  parameter int P_PHY_W  = PHY_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [P_PHY_W-1:0] phy,
  input  logic [1:0]         thresh,
  input  logic               eng_busy,
  input  logic               eng_done,
  output logic               active,
  output logic               issue,
  output tune_req_t          req
);
  logic               active_q, wait_q;
  logic [1:0]         step_q;
  logic [P_PHY_W-1:0] phy_q;
  logic [1:0]         thr_q;

  assign issue  = active_q && !wait_q && !eng_busy;
  assign active = active_q;

  always_comb begin
    req.phy = phy_q;
    case (step_q)
      2'd0: begin req.addr = ADR_CAL; req.data = VAL_CAL; req.len = LEN_CAL; end
      2'd1: begin req.addr = ADR_AMP; req.data = VAL_AMP; req.len = LEN_AMP; end
      default: begin
        req.addr = ADR_DISC;
        req.data = {{(P_DATA_W-2){1'b0}}, thr_q};
        req.len  = LEN_DISC;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      step_q   <= 2'd0;
      phy_q    <= '0;
      thr_q    <= 2'd0;
    end else if (go) begin
      active_q <= 1'b1;
      wait_q   <= 1'b0;
      step_q   <= (phy == '0) ? 2'd0 : 2'd1;
      phy_q    <= phy;
      thr_q    <= thresh;
    end else if (active_q) begin
      if (issue) wait_q <= 1'b1;
      if (eng_done && wait_q) begin
        wait_q <= 1'b0;
        if (step_q == 2'd2) active_q <= 1'b0;
        else step_q <= step_q + 2'd1;
      end
    end
  end

  assert_cal_phy0_R9: assert property (@(posedge clk) disable iff (rst)
    (issue && step_q == 2'd0) |-> (phy_q == '0));
  assert_seq_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (active_q && wait_q) |-> (eng_busy || eng_done));
endmodule

// File: rtl/tune_src_arb.sv
module tune_src_arb
  import phy_tune_pkg::*;
#(
  parameter int P_PHY_W  = PHY_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_LEN_W  = LEN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busy,
  input  logic                init_req,
  input  logic                sq_req,
  input  logic                sq_on,
  input  logic                wr_req,
  input  logic [P_PHY_W-1:0]  phy_sel,
  input  logic [P_ADDR_W-1:0] wr_addr,
  input  logic [P_DATA_W-1:0] wr_data,
  input  logic [P_LEN_W-1:0]  wr_len,
  input  logic                seq_issue,
  input  tune_req_t           seq_req,
  output logic                init_go,
  output logic                eng_start,
  output tune_req_t           eng_req
);
  logic g_sq, g_wr;
  tune_req_t sq_pkt, wr_pkt;

  assign init_go = !busy && init_req;
  assign g_sq    = !busy && !init_req && sq_req;
  assign g_wr    = !busy && !init_req && !sq_req && wr_req;
  assign eng_start = seq_issue || g_sq || g_wr;

  assign sq_pkt = '{addr: ADR_SQ, data: (sq_on ? VAL_SQ_ON : VAL_SQ_OFF),
                    len: LEN_SQ, phy: phy_sel};
  assign wr_pkt = '{addr: wr_addr, data: wr_data, len: wr_len, phy: phy_sel};

  always_comb begin
    if (seq_issue)  eng_req = seq_req;
    else if (g_sq)  eng_req = sq_pkt;
    else            eng_req = wr_pkt;
  end

  assert_one_source_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seq_issue, init_go, g_sq, g_wr}));
  assert_refuse_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(init_go || g_sq || g_wr));
endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phy_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_clear_first,
  input  logic [1:0]        cfg_disc_thresh,
  input  logic [PHY_W-1:0]  phy_sel,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              init_req,
  input  logic              sq_req,
  input  logic              sq_on,
  output logic              busy,
  output logic              done,
  output logic              ctl_wr,
  output logic [CTL_W-1:0]  ctl_reg
);
  logic      eng_busy, eng_done, seq_active, seq_issue, init_go, eng_start;
  tune_req_t seq_req, eng_req;

  assign busy = eng_busy || seq_active;
  assign done = eng_done;

  tune_src_arb u_arb (
    .clk(clk), .rst(rst), .busy(busy),
    .init_req(init_req), .sq_req(sq_req), .sq_on(sq_on), .wr_req(wr_req),
    .phy_sel(phy_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_len(wr_len),
    .seq_issue(seq_issue), .seq_req(seq_req),
    .init_go(init_go), .eng_start(eng_start), .eng_req(eng_req)
  );

  tune_init_seq u_seq (
    .clk(clk), .rst(rst), .go(init_go), .phy(phy_sel),
    .thresh(cfg_disc_thresh), .eng_busy(eng_busy), .eng_done(eng_done),
    .active(seq_active), .issue(seq_issue), .req(seq_req)
  );

  tune_bit_engine u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .req(eng_req),
    .clear_first(cfg_clear_first), .eng_busy(eng_busy), .done(eng_done),
    .ctl_wr(ctl_wr), .ctl_reg(ctl_reg)
  );

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !seq_active) |-> !busy);
  assert_write_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !done) |-> eng_busy);
endmodule

// File: tb/tb_phy_tune_writer.sv
`timescale 1ns/1ps
module tb_phy_tune_writer;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_clear_first = 1'b0;
  logic [1:0] cfg_disc_thresh = 2'd3;
  logic [1:0] phy_sel = 2'd0;
  logic wr_req = 1'b0, init_req = 1'b0, sq_req = 1'b0, sq_on = 1'b0;
  logic [7:0] wr_addr = 8'h0, wr_data = 8'h0;
  logic [3:0] wr_len = 4'h0;
  logic busy, done, ctl_wr;
  logic [31:0] ctl_reg;

  always #5 clk = ~clk;

  phy_tune_writer dut (.*);

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m = 32'h0;
  int checks = 0, fails = 0, n_wr = 0, n_done = 0, n_done_exp = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // scoreboard driver side: predicted writes of one transfer
  task automatic model_xfer(input logic [7:0] a, input logic [7:0] d, input int len,
                            input int p, input bit clr, input string t);
    int l = (len > 8) ? 8 : len;
    n_done_exp++;
    if (l == 0) return;
    if (clr) begin m = 32'h0; push(m, t); end
    for (int i = 0; i < l; i++) begin
      m[15:8] = a + 8'(i); push(m, t);
      m[7] = d[i]; m[2*p] = 1'b0; push(m, t);
      m[2*p] = 1'b1; push(m, t);
      m[2*p] = 1'b0; push(m, t);
    end
  endtask

  // monitor: compare every register write in order
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (!rst && done) n_done++;
    if (!rst && ctl_wr) begin
      n_wr++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6/R11 unexpected write: actual %0h expected none", ctl_reg);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ctl_reg == e, t, "register write", ctl_reg, e);
      end
    end
  end

  task automatic send_wr(input logic [7:0] a, input logic [7:0] d,
                         input logic [3:0] len, input logic [1:0] p);
    @(negedge clk);
    phy_sel = p; wr_addr = a; wr_data = d; wr_len = len; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic wait_idle(input string t);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(!busy, t, "busy released", 32'(busy), 32'h0);
    @(negedge clk);
    chk(exp_q.size() == 0, t, "all predicted writes seen", exp_q.size(), 32'h0);
  endtask

  task automatic run_wr(input logic [7:0] a, input logic [7:0] d, input logic [3:0] len,
                        input logic [1:0] p, input string t);
    model_xfer(a, d, int'(len), int'(p), cfg_clear_first, t);
    send_wr(a, d, len, p);
    chk(busy == 1'b1, "R6", "busy after acceptance", 32'(busy), 32'h1);
    wait_idle(t);
  endtask

  task automatic model_init(input int p, input logic [1:0] thr);
    if (p == 0) model_xfer(8'h0c, 8'h01, 1, p, cfg_clear_first, "R9 cal");
    model_xfer(8'h20, 8'h14, 5, p, cfg_clear_first, "R9 amp");
    model_xfer(8'h2a, {6'b0, thr}, 2, p, cfg_clear_first, "R9 disc");
  endtask

  task automatic run_sq(input bit on, input logic [1:0] p);
    model_xfer(8'h3c, on ? 8'h00 : 8'h02, 2, int'(p), cfg_clear_first, "R10");
    @(negedge clk);
    phy_sel = p; sq_on = on; sq_req = 1'b1;
    @(negedge clk);
    sq_req = 1'b0;
    wait_idle("R10");
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(ctl_reg == 32'h0, "R12", "reset register", ctl_reg, 32'h0);
    chk(!busy && !done && !ctl_wr, "R12", "reset flags", {busy, done, ctl_wr}, 32'h0);

    // R1 R2 R3 R5 basic transfer, PHY 0
    run_wr(8'h20, 8'h14, 4'd5, 2'd0, "R1/R2/R3/R5");
    // R4 clear-first, PHY 3, address wrap past 0xff
    cfg_clear_first = 1'b1;
    run_wr(8'hfe, 8'ha5, 4'd8, 2'd3, "R4/R1");
    cfg_clear_first = 1'b0;

    // R6 requests while busy are dropped
    model_xfer(8'h40, 8'h06, 3, 1, 1'b0, "R6");
    send_wr(8'h40, 8'h06, 4'd3, 2'd1);
    @(negedge clk);
    wr_addr = 8'h55; wr_len = 4'd4; wr_req = 1'b1; sq_req = 1'b1; init_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; sq_req = 1'b0; init_req = 1'b0;
    wait_idle("R6");

    // R7 zero length
    w0 = n_wr;
    model_xfer(8'h10, 8'hff, 0, 2, 1'b0, "R7");
    send_wr(8'h10, 8'hff, 4'd0, 2'd2);
    chk(done == 1'b1, "R7", "done after zero length", 32'(done), 32'h1);
    chk(busy == 1'b0, "R7", "busy stays low", 32'(busy), 32'h0);
    repeat (4) @(negedge clk);
    chk(n_wr == w0, "R7", "no writes for zero length", n_wr, w0);

    // R8 clamp of length 15 to 8
    w0 = n_wr;
    run_wr(8'h30, 8'h5a, 4'd15, 2'd2, "R8");
    chk(n_wr - w0 == 32, "R8", "write count for clamped length", n_wr - w0, 32);

    // R9 power-up sequence on PHY 0 and PHY 2
    cfg_disc_thresh = 2'd3;
    model_init(0, 2'd3);
    @(negedge clk); phy_sel = 2'd0; init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    chk(busy == 1'b1, "R9", "busy during sequence", 32'(busy), 32'h1);
    wait_idle("R9");
    cfg_clear_first = 1'b1; cfg_disc_thresh = 2'd2;
    model_init(2, 2'd2);
    @(negedge clk); phy_sel = 2'd2; init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    wait_idle("R9");
    cfg_clear_first = 1'b0;

    // R10 squelch on and off
    run_sq(1'b1, 2'd1);
    run_sq(1'b0, 2'd1);

    // R11 all three at once: power-up wins
    cfg_disc_thresh = 2'd3;
    model_init(1, 2'd3);
    @(negedge clk);
    phy_sel = 2'd1; init_req = 1'b1; sq_req = 1'b1; sq_on = 1'b1;
    wr_req = 1'b1; wr_addr = 8'h77; wr_len = 4'd2;
    @(negedge clk);
    init_req = 1'b0; sq_req = 1'b0; wr_req = 1'b0;
    wait_idle("R11");
    // R11 squelch beats direct
    model_xfer(8'h3c, 8'h02, 2, 3, 1'b0, "R11");
    @(negedge clk);
    phy_sel = 2'd3; sq_req = 1'b1; sq_on = 1'b0; wr_req = 1'b1;
    @(negedge clk);
    sq_req = 1'b0; wr_req = 1'b0;
    wait_idle("R11");

    // R5 one done per transfer
    chk(n_done == n_done_exp, "R5", "done pulse count", n_done, n_done_exp);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule